// File: doc/BRIEF.md
# Interrupt Pin Glitch Filter

This block cleans up a group of asynchronous interrupt pins before the rest of the chip sees them. It takes sixteen maskable request pins and two non-maskable pins. Each pin passes through a two-flop synchronizer. A per-pin counter then qualifies it: a new level is accepted only after the pin has held that level for a programmable number of clocks. One 4-bit length input sets that number for all eighteen pins at once. A setting of `L` requires `2^L` consecutive samples. Together with the synchronizer, this gives a filter period of `2^L + 1` clock periods, so the shortest period is two clocks.

The accepted levels are presented on a 32-bit read-only status word. Each bit is inverted, so a bit reads 1 when a low level has been accepted on its pin. The two non-maskable pins sit at the top of the word, the sixteen request pins fill the low half, and the bits between them read zero. Edge detection, flag generation and any bus access to the word belong to the logic around this block.

Top module: `irq_glitch_filter`

## Requirements
- R1: While reset is asserted and immediately after it is released, every bit of `status_o` is 0. Every pin's accepted level starts high.
- R2: Bits 29 down to 16 of `status_o` always read 0.
- R3: `status_o[31]` reports non-maskable pin 0 and `status_o[30]` reports non-maskable pin 1. `status_o[i]` reports request pin `i` for `i` from 0 to 15.
- R4: Each reporting bit is the inverse of its pin's accepted level. It reads 1 when a low level has been accepted and 0 when a high level has been accepted.
- R5: Let `P = 2^len_i`. Suppose a pin differs from its accepted level and is sampled at that new level on `P` consecutive rising edges. Then the new level is accepted, and the status bit changes on rising edge `P+2`, counting the first sampling edge as edge 1.
- R6: A pin excursion sampled on `P-1` or fewer consecutive rising edges never changes the status bit.
- R7: When `len_i` changes, all partial counts are discarded on the edge that first sees the new value. Counting restarts under the new period, beginning with the pin sample taken one edge earlier.
- R8: Each pin is filtered on its own. Activity on one pin never changes the status bit of another pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| len_i | input | 4 | Filter length exponent shared by all pins |
| irq_pin_i | input | 16 | Asynchronous request pins |
| nmi_pin_i | input | 2 | Asynchronous non-maskable pins |
| status_o | output | 32 | Inverted accepted levels |

## Verification
The bench drives pulses of exactly `P-1` and `P` samples at lengths 0, 1 and 4. It records the edge on which each status bit moves. A design with an off-by-one counter would either let the shorter pulse through or report the longer one an edge early or late. A mid-count length change checks that partial counts are really thrown away; a design that kept them would accept the pin four edges too soon. Random pin traffic is compared each cycle against a bench model. That comparison catches swapped or non-inverted bit positions, a non-zero gap, and crosstalk between pins.

// File: rtl/ifilt_pkg.sv
package ifilt_pkg;
    localparam int unsigned LEN_W = 4;
    localparam int unsigned CNT_W = 1 << LEN_W;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        cnt_t cnt;
        logic filt;
    } stage_t;
endpackage

// File: rtl/ifilt_sync.sv
module ifilt_sync #(
    parameter int unsigned W      = 18,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chain_q <= '1;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/ifilt_stage.sv
module ifilt_stage
    import ifilt_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic smp_i,
    input  logic restart_i,
    input  cnt_t limit_i,
    output logic filt_o
);
    stage_t st_d, st_q;
    cnt_t   cnt_inc;

    always_comb begin
        st_d    = st_q;
        cnt_inc = st_q.cnt + cnt_t'(1);
        if (restart_i) begin
            st_d.cnt = '0;
        end else if (smp_i != st_q.filt) begin
            if (cnt_inc == limit_i) begin
                st_d.filt = smp_i;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt  = cnt_inc;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{cnt: '0, filt: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign filt_o = st_q.filt;

    AST_CNT_BELOW_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt < limit_i); // R5
    AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt != '0 |-> st_q.cnt == cnt_t'($past(st_q.cnt) + cnt_t'(1))); // R6
    AST_MATCH_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        smp_i == st_q.filt |=> $stable(st_q.filt)); // R6
    AST_RESTART_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_i |=> (st_q.cnt == '0 && $stable(st_q.filt))); // R7
endmodule

// File: rtl/ifilt_status.sv
module ifilt_status #(
    parameter int unsigned NUM_IRQ  = 16,
    parameter int unsigned NUM_NMI  = 2,
    parameter int unsigned STATUS_W = 32
) (
    input  logic [NUM_IRQ-1:0]  irq_filt_i,
    input  logic [NUM_NMI-1:0]  nmi_filt_i,
    output logic [STATUS_W-1:0] status_o
);
    always_comb begin
        status_o = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            status_o[i] = ~irq_filt_i[i];
        end
        for (int j = 0; j < NUM_NMI; j++) begin
            status_o[STATUS_W-1-j] = ~nmi_filt_i[j];
        end
    end
endmodule

// File: rtl/irq_glitch_filter.sv
module irq_glitch_filter
    import ifilt_pkg::*;
#(
    parameter int unsigned NUM_IRQ     = 16,
    parameter int unsigned NUM_NMI     = 2,
    parameter int unsigned STATUS_W    = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [LEN_W-1:0]    len_i,
    input  logic [NUM_IRQ-1:0]  irq_pin_i,
    input  logic [NUM_NMI-1:0]  nmi_pin_i,
    output logic [STATUS_W-1:0] status_o
);
    localparam int unsigned NUM_PIN = NUM_IRQ + NUM_NMI;

    typedef struct packed {
        logic [LEN_W-1:0] len;
    } top_state_t;

    top_state_t         top_d, top_q;
    logic [NUM_PIN-1:0] pins, synced, filt;
    logic               restart;
    cnt_t               limit;

    assign pins = {nmi_pin_i, irq_pin_i};

    always_comb begin
        top_d     = top_q;
        top_d.len = len_i;
        restart   = (len_i != top_q.len);
        limit     = cnt_t'(1) << top_q.len;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            top_q <= '{len: '0};
        end else begin
            top_q <= top_d;
        end
    end

    ifilt_sync #(.W(NUM_PIN), .STAGES(SYNC_STAGES)) i_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (pins),
        .sync_o  (synced)
    );

    for (genvar p = 0; p < NUM_PIN; p++) begin : g_stage
        ifilt_stage i_stage (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .smp_i     (synced[p]),
            .restart_i (restart),
            .limit_i   (limit),
            .filt_o    (filt[p])
        );
    end

    ifilt_status #(.NUM_IRQ(NUM_IRQ), .NUM_NMI(NUM_NMI), .STATUS_W(STATUS_W)) i_status (
        .irq_filt_i (filt[NUM_IRQ-1:0]),
        .nmi_filt_i (filt[NUM_PIN-1:NUM_IRQ]),
        .status_o   (status_o)
    );
endmodule

// File: tb/test_irq_glitch_filter.sv
module test_irq_glitch_filter;
    localparam int CLK_PERIOD = 10;
    localparam int NPIN = 18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  len = 4'd0;
    logic [17:0] pins = '1;
    logic [31:0] status;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic        m_acc [NPIN];
    int          m_run [NPIN];
    logic [17:0] m_d1, m_d2;
    logic [3:0]  m_len_prev;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_glitch_filter i_irq_glitch_filter (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .len_i     (len),
        .irq_pin_i (pins[15:0]),
        .nmi_pin_i (pins[17:16]),
        .status_o  (status)
    );

    function automatic int bitpos(int idx);
        return (idx < 16) ? idx : 31 - (idx - 16);
    endfunction

    function automatic logic [31:0] model_status();
        logic [31:0] w = '0;
        for (int i = 0; i < NPIN; i++) w[bitpos(i)] = ~m_acc[i];
        return w;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NPIN; i++) begin
            m_acc[i] = 1'b1;
            m_run[i] = 0;
        end
        m_d1 = '1;
        m_d2 = '1;
        m_len_prev = 4'd0;
    endtask

    task automatic model_step();
        bit restart = (len != m_len_prev);
        int need = 1 << m_len_prev;
        for (int i = 0; i < NPIN; i++) begin
            if (restart) m_run[i] = 0;
            else if (m_d2[i] != m_acc[i]) begin
                m_run[i]++;
                if (m_run[i] == need) begin
                    m_acc[i] = m_d2[i];
                    m_run[i] = 0;
                end
            end else m_run[i] = 0;
        end
        m_d2 = m_d1;
        m_d1 = pins;
        m_len_prev = len;
    endtask

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(status == model_status(), "R3/R4 model compare", status, model_status());
        check(status[29:16] == 14'd0, "R2 gap bits", status, status & ~32'h3FFF_0000);
    endtask

    task automatic set_len(logic [3:0] v);
        len = v;
        repeat (4) tick();
    endtask

    // drive pin idx low for w samples; return edge index of first set status bit (0 = never)
    task automatic pulse(int idx, int w, output int first);
        int p = 1 << len;
        int total = w + 2 * p + 8;
        logic [31:0] mask = 32'd1 << bitpos(idx);
        first = 0;
        pins[idx] = 1'b0;
        for (int t = 1; t <= total; t++) begin
            tick();
            if (t == w) pins[idx] = 1'b1;
            if (first == 0 && status[bitpos(idx)]) first = t;
            check((status & ~mask) == 32'd0, "R8 other pins untouched", status, status & mask);
        end
    endtask

    task automatic pulse_case(int idx, logic [3:0] l, int w, string req);
        int first;
        int p;
        set_len(l);
        p = 1 << l;
        pulse(idx, w, first);
        if (w >= p) check(first == p + 2, req, 32'(first), 32'(p + 2));
        else        check(first == 0, req, 32'(first), 32'd0);
    endtask

    initial begin
        int first;
        void'($urandom(32'h5EED_1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(status == 32'd0, "R1 status in reset", status, 32'd0);
        rst_n = 1'b1;
        model_reset();
        check(status == 32'd0, "R1 status after release", status, 32'd0);
        repeat (3) tick();

        pulse_case(3, 4'd0, 1, "R5 len0 pulse of P accepted");
        pulse_case(5, 4'd1, 1, "R6 len1 pulse of P-1 rejected");
        pulse_case(5, 4'd1, 2, "R5 len1 pulse of P accepted");
        pulse_case(17, 4'd1, 2, "R3 R5 nmi1 len1 accepted");
        pulse_case(16, 4'd4, 15, "R6 nmi0 len4 pulse of P-1 rejected");
        pulse_case(16, 4'd4, 16, "R5 nmi0 len4 pulse of P accepted");
        pulse_case(0, 4'd4, 15, "R6 irq0 len4 pulse of P-1 rejected");
        pulse_case(15, 4'd4, 40, "R5 irq15 len4 long level");

        // R7: length change in mid-count
        set_len(4'd3);
        pins[7] = 1'b0;
        first = 0;
        for (int t = 1; t <= 60; t++) begin
            tick();
            if (t == 5) len = 4'd4;
            if (first == 0 && status[7]) first = t;
        end
        check(first == 22, "R7 restart on length change", 32'(first), 32'd22);
        check(status[7] == 1'b1, "R4 low level reads one", status, 32'h80);
        pins[7] = 1'b1;
        repeat (40) tick();
        check(status == 32'd0, "R4 high level reads zero", status, 32'd0);

        // random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(199) == 0) len = 4'($urandom_range(3));
            for (int i = 0; i < NPIN; i++) begin
                if ($urandom_range(5) == 0) pins[i] = ~pins[i];
            end
            tick();
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule